// File: doc/BRIEF.md
# Banked Floating-Point Context Register File

This block holds the control state that a processor core keeps for its floating-point context: a context control word, a context frame address, a default status word, a coprocessor access word and a secure-only access control word. Every bus access carries a secure attribute. The address, default status and coprocessor access words have a separate copy for each security state. The context control word mixes the two kinds of field. Some of its fields have a copy per state. The others exist once, and the non-secure side can see and change only part of them.

Reads are combinational from the offset and the secure attribute. Writes take effect on the next rising clock edge. Three configuration inputs shape the behaviour: whether floating point is present, whether the core runs at the v8 or the v7 feature level, and whether HardFault handling is opened to the non-secure side. Every stored copy is also driven out as a port for the surrounding core logic.

Top module: `fpctx_regfile`

## Requirements
- R1: After reset every stored copy is zero, and every mapped offset reads zero from either security state.
- R2: When `cfg_fp_present` is 0, every mapped offset reads zero and writes change no stored copy.
- R3: Byte offsets 0x00 (context control), 0x04 (context address), 0x08 (default status), 0x0C (coprocessor access) and 0x10 (secure-only access) are mapped. Any other offset reads zero with `addr_err` high, and `addr_err` is low on a mapped offset.
- R4: A secure read of context control returns the secure copy. Its bit positions are: 0 lazy-active, 1 user, 2 secure-stack, 3 thread, 4 HardFault-ready, 5 mem-ready, 6 bus-ready, 7 secure-ready, 8 monitor-ready, 9 stack-limit, 10 usage-ready, 26 treat-as-secure, 27 clear-on-return lock, 28 clear-on-return, 29 lazy-enable lock, 30 lazy-enable, 31 auto-enable.
- R5: A non-secure read of context control returns bits 30, 28 and 8 of the secure copy, OR'd with the non-secure copy.
- R6: With `cfg_ns_hardfault` set, a non-secure read of context control also exposes bits 4 and 6 of the secure copy.
- R7: Bits 25:11 of a context control write are always discarded. With `cfg_v8_level` low, only bits 31, 30, 8, 6, 5, 4, 3, 1 and 0 (mask 0xC000017B) of the write are kept.
- R8: A non-secure context control write changes shared bit 30 only when secure bit 29 is clear, and changes shared bit 28 only when secure bit 27 is clear.
- R9: A non-secure context control write changes shared bits 4 and 6 only when `cfg_ns_hardfault` is set, and always changes bit 8. The banked bits (mask 0x0000062B) go to the non-secure copy. No other secure bit changes.
- R10: The context address word has one copy per state, and a write clears its bits 2:0. The default status word has one copy per state and keeps only the bits under mask 0x07C00000.
- R11: The coprocessor access word has one copy per state and keeps only bits 23:20.
- R12: The secure-only access word keeps bits 11:10 from secure writes. Non-secure writes to it are ignored, and non-secure reads of it return zero.
- R13: A write and a read of the same offset in one cycle return the old contents. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_secure | input | 1 | Access is from the secure state |
| cfg_fp_present | input | 1 | Floating point is implemented |
| cfg_v8_level | input | 1 | v8 feature level (0 = v7) |
| cfg_ns_hardfault | input | 1 | HardFault handling opened to the non-secure side |
| rd_data | output | DATA_W | Combinational read data |
| addr_err | output | 1 | Offset is unmapped |
| ctxctl_s_q | output | DATA_W | Context control, secure copy |
| ctxctl_ns_q | output | DATA_W | Context control, non-secure banked copy |
| ctxaddr_s_q | output | DATA_W | Context address, secure copy |
| ctxaddr_ns_q | output | DATA_W | Context address, non-secure copy |
| dfltstat_s_q | output | DATA_W | Default status, secure copy |
| dfltstat_ns_q | output | DATA_W | Default status, non-secure copy |
| cpaccess_s_q | output | DATA_W | Coprocessor access, secure copy |
| cpaccess_ns_q | output | DATA_W | Coprocessor access, non-secure copy |
| nsaccess_q | output | DATA_W | Secure-only access word |

## Verification
A write and a read can hit the same offset in the same cycle, because one offset drives both paths. The bench provokes this by writing context control while the read data of that very offset is sampled. It expects the pre-write contents in that cycle and the new value on the following access. A second overlap is a non-secure write that hits lock-guarded shared bits while the secure write mask and the v7 mask are both in force. The bench judges the merged result through secure and non-secure read-back.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

  localparam int NUM_REGS = 5;

  localparam int IDX_CTL = 0;
  localparam int IDX_ADR = 1;
  localparam int IDX_DST = 2;
  localparam int IDX_CPA = 3;
  localparam int IDX_NSA = 4;

  // context control bit positions
  localparam int B_LAZY_ACT  = 0;
  localparam int B_USER      = 1;
  localparam int B_THREAD    = 3;
  localparam int B_HF_RDY    = 4;
  localparam int B_MEM_RDY   = 5;
  localparam int B_BUS_RDY   = 6;
  localparam int B_MON_RDY   = 8;
  localparam int B_STK_LIM   = 9;
  localparam int B_USE_RDY   = 10;
  localparam int B_CLR_LOCK  = 27;
  localparam int B_CLR_RET   = 28;
  localparam int B_LAZY_LOCK = 29;
  localparam int B_LAZY_EN   = 30;
  localparam int B_AUTO_EN   = 31;

  localparam logic [31:0] CTL_RES0_MASK = 32'h03FF_F800;
  localparam logic [31:0] CTL_V7_KEEP   = (32'h1 << B_LAZY_ACT) | (32'h1 << B_USER)
                                        | (32'h1 << B_THREAD)   | (32'h1 << B_HF_RDY)
                                        | (32'h1 << B_MEM_RDY)  | (32'h1 << B_BUS_RDY)
                                        | (32'h1 << B_MON_RDY)  | (32'h1 << B_LAZY_EN)
                                        | (32'h1 << B_AUTO_EN);
  localparam logic [31:0] CTL_BANKED    = (32'h1 << B_LAZY_ACT) | (32'h1 << B_USER)
                                        | (32'h1 << B_THREAD)   | (32'h1 << B_MEM_RDY)
                                        | (32'h1 << B_STK_LIM)  | (32'h1 << B_USE_RDY);
  localparam logic [31:0] CTL_NS_VIS    = (32'h1 << B_LAZY_EN) | (32'h1 << B_CLR_RET)
                                        | (32'h1 << B_MON_RDY);
  localparam logic [31:0] CTL_NS_VIS_HF = (32'h1 << B_HF_RDY) | (32'h1 << B_BUS_RDY);

  localparam logic [31:0] ADR_KEEP = 32'hFFFF_FFF8;
  localparam logic [31:0] DST_KEEP = 32'h07C0_0000;
  localparam logic [31:0] CPA_KEEP = 32'h00F0_0000;
  localparam logic [31:0] NSA_KEEP = 32'h0000_0C00;

endpackage

// File: rtl/fpctx_decode.sv
module fpctx_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 5
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                unmapped
);
  localparam int STRIDE = 4;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i * STRIDE));
  end

  assign unmapped = ~|sel;
endmodule

// File: rtl/fpctx_pair_bank.sv
module fpctx_pair_bank #(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] KEEP        = 32'hFFFF_FFFF,
  parameter bit          SECURE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_sec,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] s_q,
  output logic [DATA_W-1:0] ns_q
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(KEEP);

  logic              s_en;
  logic [DATA_W-1:0] s_d;

  assign s_en = wr_en & wr_sec;
  assign s_d  = wdata & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= '0;
    else if (s_en) s_q <= s_d;
  end

  if (SECURE_ONLY) begin : g_sec_only
    assign ns_q   = '0;
    assign rd_val = rd_sec ? s_q : '0;
  end else begin : g_banked
    logic              ns_en;
    logic [DATA_W-1:0] ns_d;
    logic [DATA_W-1:0] ns_r;

    assign ns_en = wr_en & ~wr_sec;
    assign ns_d  = wdata & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ns_r <= '0;
      else if (ns_en) ns_r <= ns_d;
    end

    assign ns_q   = ns_r;
    assign rd_val = rd_sec ? s_q : ns_r;
  end
endmodule

// File: rtl/fpctx_ctl_bank.sv
module fpctx_ctl_bank
  import fpctx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sec,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_sec,
  input  logic              cfg_v8,
  input  logic              cfg_ns_hf,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] s_q,
  output logic [DATA_W-1:0] ns_q
);
  localparam logic [DATA_W-1:0] RES0   = DATA_W'(CTL_RES0_MASK);
  localparam logic [DATA_W-1:0] V7K    = DATA_W'(CTL_V7_KEEP);
  localparam logic [DATA_W-1:0] BANKED = DATA_W'(CTL_BANKED);
  localparam logic [DATA_W-1:0] VIS    = DATA_W'(CTL_NS_VIS);
  localparam logic [DATA_W-1:0] VIS_HF = DATA_W'(CTL_NS_VIS_HF);

  logic [DATA_W-1:0] wv;
  logic [DATA_W-1:0] s_d;
  logic [DATA_W-1:0] ns_d;
  logic [DATA_W-1:0] ns_mask;

  // next-state
  always_comb begin
    wv = wdata & ~RES0;
    if (!cfg_v8) wv = wv & V7K;
    s_d  = s_q;
    ns_d = ns_q;
    if (wr_sec) begin
      s_d = wv;
    end else begin
      if (!s_q[B_LAZY_LOCK]) s_d[B_LAZY_EN] = wv[B_LAZY_EN];
      if (!s_q[B_CLR_LOCK])  s_d[B_CLR_RET] = wv[B_CLR_RET];
      if (cfg_ns_hf) begin
        s_d[B_HF_RDY]  = wv[B_HF_RDY];
        s_d[B_BUS_RDY] = wv[B_BUS_RDY];
      end
      s_d[B_MON_RDY] = wv[B_MON_RDY];
      ns_d = wv & BANKED;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= '0;
      ns_q <= '0;
    end else if (wr_en) begin
      s_q  <= s_d;
      ns_q <= ns_d;
    end
  end

  // read merge
  assign ns_mask = cfg_ns_hf ? (VIS | VIS_HF) : VIS;
  assign rd_val  = rd_sec ? s_q : ((s_q & ns_mask) | ns_q);

  // R8: a locked lazy-enable bit survives a non-secure write
  p_lazy_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sec && s_q[B_LAZY_LOCK]) |=> (s_q[B_LAZY_EN] == $past(s_q[B_LAZY_EN])));

  // R9: without the HardFault opening, a non-secure write leaves bits 4 and 6 alone
  p_hf_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sec && !cfg_ns_hf) |=>
      (s_q[B_HF_RDY] == $past(s_q[B_HF_RDY]) && s_q[B_BUS_RDY] == $past(s_q[B_BUS_RDY])));

  // R7: reserved bits never land in either copy after a write
  p_res0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((s_q & RES0) == '0 && (ns_q & RES0) == '0));
endmodule

// File: rtl/fpctx_regfile.sv
module fpctx_regfile
  import fpctx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_secure,
  input  logic              cfg_fp_present,
  input  logic              cfg_v8_level,
  input  logic              cfg_ns_hardfault,
  output logic [DATA_W-1:0] rd_data,
  output logic              addr_err,
  output logic [DATA_W-1:0] ctxctl_s_q,
  output logic [DATA_W-1:0] ctxctl_ns_q,
  output logic [DATA_W-1:0] ctxaddr_s_q,
  output logic [DATA_W-1:0] ctxaddr_ns_q,
  output logic [DATA_W-1:0] dfltstat_s_q,
  output logic [DATA_W-1:0] dfltstat_ns_q,
  output logic [DATA_W-1:0] cpaccess_s_q,
  output logic [DATA_W-1:0] cpaccess_ns_q,
  output logic [DATA_W-1:0] nsaccess_q
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wen;
  logic [DATA_W-1:0]   rd_vals [NUM_REGS];
  logic [DATA_W-1:0]   nsa_s_q;
  logic [DATA_W-1:0]   nsa_ns_q;
  logic [DATA_W-1:0]   rd_sel;

  fpctx_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr(bus_addr), .sel(sel), .unmapped(addr_err)
  );

  assign wen = sel & {NUM_REGS{bus_we & cfg_fp_present}};

  fpctx_ctl_bank #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wen[IDX_CTL]), .wr_sec(bus_secure),
    .wdata(bus_wdata), .rd_sec(bus_secure), .cfg_v8(cfg_v8_level),
    .cfg_ns_hf(cfg_ns_hardfault), .rd_val(rd_vals[IDX_CTL]),
    .s_q(ctxctl_s_q), .ns_q(ctxctl_ns_q)
  );

  fpctx_pair_bank #(.DATA_W(DATA_W), .KEEP(ADR_KEEP), .SECURE_ONLY(1'b0)) u_adr (
    .clk(clk), .rst_n(rst_n), .wr_en(wen[IDX_ADR]), .wr_sec(bus_secure),
    .wdata(bus_wdata), .rd_sec(bus_secure), .rd_val(rd_vals[IDX_ADR]),
    .s_q(ctxaddr_s_q), .ns_q(ctxaddr_ns_q)
  );

  fpctx_pair_bank #(.DATA_W(DATA_W), .KEEP(DST_KEEP), .SECURE_ONLY(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .wr_en(wen[IDX_DST]), .wr_sec(bus_secure),
    .wdata(bus_wdata), .rd_sec(bus_secure), .rd_val(rd_vals[IDX_DST]),
    .s_q(dfltstat_s_q), .ns_q(dfltstat_ns_q)
  );

  fpctx_pair_bank #(.DATA_W(DATA_W), .KEEP(CPA_KEEP), .SECURE_ONLY(1'b0)) u_cpa (
    .clk(clk), .rst_n(rst_n), .wr_en(wen[IDX_CPA]), .wr_sec(bus_secure),
    .wdata(bus_wdata), .rd_sec(bus_secure), .rd_val(rd_vals[IDX_CPA]),
    .s_q(cpaccess_s_q), .ns_q(cpaccess_ns_q)
  );

  fpctx_pair_bank #(.DATA_W(DATA_W), .KEEP(NSA_KEEP), .SECURE_ONLY(1'b1)) u_nsa (
    .clk(clk), .rst_n(rst_n), .wr_en(wen[IDX_NSA]), .wr_sec(bus_secure),
    .wdata(bus_wdata), .rd_sec(bus_secure), .rd_val(rd_vals[IDX_NSA]),
    .s_q(nsa_s_q), .ns_q(nsa_ns_q)
  );

  assign nsaccess_q = nsa_s_q | nsa_ns_q;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rd_sel = rd_sel | rd_vals[i];
    end
  end

  assign rd_data = cfg_fp_present ? rd_sel : '0;

  // R2: with floating point absent, a write leaves the stored copies unchanged
  p_absent_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fp_present |=> ($stable(ctxctl_s_q) && $stable(ctxctl_ns_q) &&
                         $stable(ctxaddr_s_q) && $stable(nsaccess_q)));

  // R3: an unmapped offset reads zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (rd_data == '0));

  // R10: a secure address write lands with its low three bits cleared
  p_addr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fp_present && bus_we && bus_secure && bus_addr == ADDR_W'(4 * IDX_ADR)) |=>
      (ctxaddr_s_q[2:0] == 3'b000 && ctxaddr_s_q[DATA_W-1:3] == $past(bus_wdata[DATA_W-1:3])));

  // R12: non-secure writes to the secure-only word are ignored
  p_nsa_ns_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_secure && bus_addr == ADDR_W'(4 * IDX_NSA)) |=> $stable(nsaccess_q));

  // R12: non-secure reads of the secure-only word return zero
  p_nsa_ns_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_secure && bus_addr == ADDR_W'(4 * IDX_NSA)) |-> (rd_data == '0));
endmodule

// File: tb/fpctx_regfile_bench.sv
`timescale 1ns/1ps
module fpctx_regfile_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] A_CTL = 8'h00, A_ADR = 8'h04, A_DST = 8'h08,
                         A_CPA = 8'h0C, A_NSA = 8'h10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_we, bus_secure;
  logic              cfg_fp_present, cfg_v8_level, cfg_ns_hardfault;
  logic [DATA_W-1:0] rd_data;
  logic              addr_err;
  logic [DATA_W-1:0] ctxctl_s_q, ctxctl_ns_q, ctxaddr_s_q, ctxaddr_ns_q;
  logic [DATA_W-1:0] dfltstat_s_q, dfltstat_ns_q, cpaccess_s_q, cpaccess_ns_q, nsaccess_q;

  typedef struct {
    logic [DATA_W-1:0] rd;
    logic              err;
    string             tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  fpctx_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fpctx_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_secure(bus_secure), .cfg_fp_present(cfg_fp_present),
    .cfg_v8_level(cfg_v8_level), .cfg_ns_hardfault(cfg_ns_hardfault),
    .rd_data(rd_data), .addr_err(addr_err),
    .ctxctl_s_q(ctxctl_s_q), .ctxctl_ns_q(ctxctl_ns_q),
    .ctxaddr_s_q(ctxaddr_s_q), .ctxaddr_ns_q(ctxaddr_ns_q),
    .dfltstat_s_q(dfltstat_s_q), .dfltstat_ns_q(dfltstat_ns_q),
    .cpaccess_s_q(cpaccess_s_q), .cpaccess_ns_q(cpaccess_ns_q),
    .nsaccess_q(nsaccess_q)
  );

  // driver: one access per cycle, expected read data pushed to the scoreboard
  task automatic acc(input logic [7:0] a, input logic [31:0] wd, input logic we,
                     input logic sec, input logic [31:0] exp_rd, input logic exp_err,
                     input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr   = a;
    bus_wdata  = wd;
    bus_we     = we;
    bus_secure = sec;
    e.rd  = exp_rd;
    e.err = exp_err;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic sec, input logic [31:0] exp_rd,
                    input string tag);
    acc(a, 32'h0, 1'b0, sec, exp_rd, 1'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd, input logic sec,
                    input logic [31:0] exp_old, input string tag);
    acc(a, wd, 1'b1, sec, exp_old, 1'b0, tag);
  endtask

  // monitor: compare read data against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rd_data !== e.rd || addr_err !== e.err) begin
          fails++;
          $display("FAIL %s: rd_data=%h err=%b expected rd_data=%h err=%b",
                   e.tag, rd_data, addr_err, e.rd, e.err);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_secure = 1'b1;
    cfg_fp_present = 1'b1; cfg_v8_level = 1'b1; cfg_ns_hardfault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_CTL, 1'b1, 32'h0, "R1 ctl secure");
    rd(A_CTL, 1'b0, 32'h0, "R1 ctl non-secure");
    rd(A_ADR, 1'b1, 32'h0, "R1 addr");
    rd(A_DST, 1'b0, 32'h0, "R1 default status");
    rd(A_CPA, 1'b1, 32'h0, "R1 cp access");
    rd(A_NSA, 1'b1, 32'h0, "R1 secure-only");

    // R3: unmapped offsets
    acc(8'h14, 32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R3 unmapped 0x14");
    acc(8'h02, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, "R3 unmapped 0x02");

    // R13 + R7: write all ones secure at v8, same-cycle read gives old value
    wr(A_CTL, 32'hFFFF_FFFF, 1'b1, 32'h0, "R13 same-cycle read");
    rd(A_CTL, 1'b1, 32'hFC00_07FF, "R4 R7 secure copy after write");
    rd(A_CTL, 1'b0, 32'h5000_0100, "R5 non-secure merge");
    cfg_ns_hardfault = 1'b1;
    rd(A_CTL, 1'b0, 32'h5000_0150, "R6 hardfault bits exposed");

    // R8/R9: locks set, hardfault opened: clear bits 4,6,8 only
    wr(A_CTL, 32'h0, 1'b0, 32'h5000_0150, "R13 ns write old value");
    rd(A_CTL, 1'b1, 32'hFC00_06AF, "R8 R9 locked ns write");

    // R8/R9: locks clear, hardfault closed
    wr(A_CTL, 32'h0, 1'b1, 32'hFC00_06AF, "R4 clear secure copy");
    cfg_ns_hardfault = 1'b0;
    wr(A_CTL, 32'hFFFF_FFFF, 1'b0, 32'h0, "R5 ns read before write");
    rd(A_CTL, 1'b1, 32'h5000_0100, "R8 R9 unlocked ns write secure view");
    rd(A_CTL, 1'b0, 32'h5000_072B, "R5 R9 ns view with banked copy");
    checks++;
    if (ctxctl_ns_q !== 32'h0000_062B) begin
      fails++;
      $display("FAIL R9 ns copy port: actual=%h expected=%h", ctxctl_ns_q, 32'h62B);
    end

    // R7: v7 feature level
    cfg_v8_level = 1'b0;
    wr(A_CTL, 32'hFFFF_FFFF, 1'b1, 32'h5000_0100, "R7 before v7 write");
    rd(A_CTL, 1'b1, 32'hC000_017B, "R7 v7 secure keep mask");
    wr(A_CTL, 32'hFFFF_FFFF, 1'b0, 32'h4000_072B, "R7 ns view before v7 ns write");
    rd(A_CTL, 1'b0, 32'h4000_012B, "R7 R8 v7 ns write");
    cfg_v8_level = 1'b1;

    // R10: context address and default status
    wr(A_ADR, 32'h1234_567F, 1'b1, 32'h0, "R10 addr secure write");
    wr(A_ADR, 32'hABCD_EF07, 1'b0, 32'h0, "R10 addr ns write");
    rd(A_ADR, 1'b1, 32'h1234_5678, "R10 addr secure");
    rd(A_ADR, 1'b0, 32'hABCD_EF00, "R10 addr ns");
    wr(A_DST, 32'hFFFF_FFFF, 1'b1, 32'h0, "R10 dflt write");
    rd(A_DST, 1'b1, 32'h07C0_0000, "R10 dflt secure mask");
    rd(A_DST, 1'b0, 32'h0, "R10 dflt ns untouched");

    // R11: coprocessor access
    wr(A_CPA, 32'hFFFF_FFFF, 1'b0, 32'h0, "R11 cpa ns write");
    rd(A_CPA, 1'b0, 32'h00F0_0000, "R11 cpa ns mask");
    rd(A_CPA, 1'b1, 32'h0, "R11 cpa secure untouched");

    // R12: secure-only access word
    wr(A_NSA, 32'hFFFF_FFFF, 1'b0, 32'h0, "R12 ns write");
    rd(A_NSA, 1'b1, 32'h0, "R12 ns write ignored");
    wr(A_NSA, 32'hFFFF_FFFF, 1'b1, 32'h0, "R12 secure write");
    rd(A_NSA, 1'b0, 32'h0, "R12 ns read zero");
    rd(A_NSA, 1'b1, 32'h0000_0C00, "R12 secure keep mask");

    // R2: floating point absent
    cfg_fp_present = 1'b0;
    rd(A_ADR, 1'b1, 32'h0, "R2 absent reads zero");
    rd(A_NSA, 1'b1, 32'h0, "R2 absent secure-only zero");
    wr(A_ADR, 32'h0, 1'b1, 32'h0, "R2 absent write");
    acc(8'h14, 32'h0, 1'b0, 1'b1, 32'h0, 1'b1, "R3 unmapped while absent");
    cfg_fp_present = 1'b1;
    rd(A_ADR, 1'b1, 32'h1234_5678, "R2 absent write ignored");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule